// File: doc/BRIEF.md
# Four-Operator FM Algorithm Router

This block forms one channel sample of a four-operator FM voice. On each internal tick it evaluates up to four operators, one at a time, through a request/response link to a shared operator unit. Each request carries a phase, an effective attenuation and a phase-modulation input. The router picks the modulation input for every operator from one of eight routing topologies, selected by a 3-bit algorithm code. It then sums the carrier outputs into a saturated 14-bit sample.

The router keeps three pieces of state across ticks. The first is a one-tick delay memory that some topologies pass from operator 2 (or operator 1) into operator 3. The second is a two-entry history of operator 1 outputs, which drives operator 1's self-feedback. The third is the last sample. A partial tick advances only the state-bearing operators and leaves the sample alone, so a controller can spread one output sample over several internal ticks. A quiet operator is skipped without a request and counts as zero.

Top module: `fm_alg_router`

## Requirements
- R1: After reset, `done` and `op_req` are 0, `sample` is 0, and the delay memory and both operator 1 history entries are 0.
- R2: Operators are requested in ascending order on `op_sel`: code 0 is operator 1 and code 3 is operator 4. While `op_req` is high and `op_ack` is low, `op_sel`, `op_phase`, `op_att` and `op_mod` hold steady. `op_out` is taken in the cycle where `op_req` and `op_ack` are both high.
- R3: Effective attenuation is the slot's attenuation field plus any AM offset. If it is 832 or more, the operator gets no request and contributes 0. Where that operator's result would be written into the delay memory, the memory becomes 0.
- R4: Slot k takes its fields from bits [k*W +: W] of `att_all` and `phase_all`, and its AM enable from `am_en[k]`, where k=0 is operator 1. When that enable is set, `lfo_am >> (3 - am_sens)` is added to the slot's attenuation.
- R5: Operator 1's modulation is 0 when `fb` is 0. Otherwise it is (older + newer history entry) shifted left by `fb`. Each tick then shifts operator 1's result into the history, or shifts in 0 if operator 1 is quiet.
- R6: Wherever operator 1 feeds another operator or the output, the value used is its result from the previous tick, which is the older history entry after the shift.
- R7: Let c1 be operator 1's previous-tick value and M the delay memory at tick start. Algorithm 0 produces op4(op3(M)) and stores op2(c1). Algorithm 1 produces op4(op3(M)) and stores c1+op2(0). Algorithm 2 produces op4(c1+op3(M)) and stores op2(0). Algorithm 3 produces op4(M+op3(0)) and stores op2(c1).
- R8: Algorithm 4 produces op2(c1)+op4(op3(0)). Algorithm 5 produces op3(M)+op2(c1)+op4(c1) and stores c1 on full ticks only. Algorithm 6 produces op2(c1)+op3(0)+op4(0). Algorithm 7 produces c1+op2(0)+op3(0)+op4(0). Algorithms 4, 6 and 7 never change the memory.
- R9: Every operator that reads the delay memory within a tick sees the value held before that tick. Algorithms 0 to 3 write the memory on both partial and full ticks.
- R10: When `full_tick` is 0 at start, only operator 1 is evaluated, plus operator 2 for algorithms 0 to 3. The sample keeps its previous value.
- R11: The channel sum saturates to the range -8192..8191.
- R12: `done` rises once the tick's last operator is handled and stays high, with `sample` unchanged, until the next accepted `start`. A `start` while a tick is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one internal tick (accepted only when idle) |
| alg | input | 3 | Algorithm code 0..7 |
| fb | input | FB_W | Operator 1 feedback shift, 0 disables |
| full_tick | input | 1 | 1: full tick forming a sample; 0: partial tick |
| am_en | input | 4 | Per-slot AM enable, bit k for operator k+1 |
| am_sens | input | 2 | AM sensitivity, selects offset shift |
| lfo_am | input | AM_W | Current LFO amplitude value |
| phase_all | input | 4*PH_W | Packed operator phases |
| att_all | input | 4*ATT_W | Packed operator attenuations |
| op_req | output | 1 | Operator evaluation request |
| op_sel | output | 2 | Operator being requested |
| op_phase | output | PH_W | Phase of requested operator |
| op_att | output | ATT_W+1 | Effective attenuation of requested operator |
| op_mod | output | MOD_W | Signed phase-modulation input |
| op_ack | input | 1 | Operator unit response valid |
| op_out | input | OUT_W | Signed operator result |
| sample | output | OUT_W | Saturated channel sample |
| done | output | 1 | Tick complete, sample valid |

## Verification
A corrupted delay memory does not show in the same tick. It shows on the next tick of algorithms 0, 1, 2, 3 or 5, as a wrong `op_mod` on operator 3 or operator 4, before any sample is formed. Damage to the feedback history shows one tick later on operator 1's `op_mod` when `fb` is nonzero, and on operator 2's `op_mod` wherever operator 1 feeds it. The bench therefore compares every request's selector and modulation value, as well as the sample, across runs of consecutive ticks with changing algorithms.

// File: rtl/fm_router_pkg.sv
package fm_router_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_OP1  = 3'd1,
      ST_OP2  = 3'd2,
      ST_OP3  = 3'd3,
      ST_OP4  = 3'd4,
      ST_FIN  = 3'd5
   } seq_state_t;
endpackage

// File: rtl/fm_att_adj.sv
module fm_att_adj #(
   parameter int ATT_W = 10,
   parameter int AM_W  = 7,
   parameter int QUIET = 832
) (
   input  logic [ATT_W-1:0] att,
   input  logic             am_on,
   input  logic [AM_W-1:0]  lfo_am,
   input  logic [1:0]       am_sens,
   output logic [ATT_W:0]   eff_att,
   output logic             quiet
);
   if (AM_W >= ATT_W) begin : g_bad_am
      $error("fm_att_adj: AM_W must be narrower than ATT_W");
   end
   if (QUIET >= (1 << (ATT_W + 1))) begin : g_bad_quiet
      $error("fm_att_adj: QUIET does not fit the effective attenuation");
   end

   logic [AM_W-1:0] ofs;

   always_comb begin
      ofs     = am_on ? (lfo_am >> (2'd3 - am_sens)) : '0;
      eff_att = {1'b0, att} + (ATT_W+1)'(ofs);
      quiet   = (eff_att >= (ATT_W+1)'(QUIET));
   end
endmodule

// File: rtl/fm_fb_hist.sv
module fm_fb_hist #(
   parameter int OUT_W = 14,
   parameter int MOD_W = 22,
   parameter int FB_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    shift_en,
   input  logic signed [OUT_W-1:0] new_val,
   input  logic [FB_W-1:0]         fb,
   output logic signed [MOD_W-1:0] fb_mod,
   output logic signed [OUT_W-1:0] older
);
   logic signed [OUT_W-1:0] h_old, h_new;
   logic signed [OUT_W:0]   pair_sum;
   logic signed [MOD_W-1:0] pair_ext;

   always_comb begin
      pair_sum = (OUT_W+1)'(h_old) + (OUT_W+1)'(h_new);
      pair_ext = MOD_W'(pair_sum);
      fb_mod   = (fb == '0) ? '0 : (pair_ext <<< fb);
      older    = h_old;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_old <= '0;
         h_new <= '0;
      end else if (shift_en) begin
         h_old <= h_new;
         h_new <= new_val;
      end
   end
endmodule

// File: rtl/fm_route_seq.sv
module fm_route_seq
   import fm_router_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] quiet,
   input  logic       op_ack,
   input  logic       full_q,
   input  logic       alg_hi,
   output seq_state_t state,
   output logic       launch,
   output logic       step,
   output logic       op_req,
   output logic [1:0] idx,
   output logic       done
);
   seq_state_t nxt;
   logic       active;

   always_comb begin
      active = (state == ST_OP1) || (state == ST_OP2) ||
               (state == ST_OP3) || (state == ST_OP4);
      case (state)
         ST_OP2:  idx = 2'd1;
         ST_OP3:  idx = 2'd2;
         ST_OP4:  idx = 2'd3;
         default: idx = 2'd0;
      endcase
      launch = start && (state == ST_IDLE);
      op_req = active && !quiet[idx];
      step   = active && (quiet[idx] || op_ack);
      nxt    = state;
      case (state)
         ST_IDLE: if (launch) nxt = ST_OP1;
         ST_OP1:  if (step) nxt = (full_q || !alg_hi) ? ST_OP2 : ST_FIN;
         ST_OP2:  if (step) nxt = full_q ? ST_OP3 : ST_FIN;
         ST_OP3:  if (step) nxt = ST_OP4;
         ST_OP4:  if (step) nxt = ST_FIN;
         ST_FIN:  nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         if (launch)
            done <= 1'b0;
         else if (state == ST_FIN)
            done <= 1'b1;
      end
   end

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_req && !op_ack |=> op_req && $stable(idx));
endmodule

// File: rtl/fm_alg_router.sv
module fm_alg_router
   import fm_router_pkg::*;
#(
   parameter int OUT_W = 14,
   parameter int PH_W  = 10,
   parameter int ATT_W = 10,
   parameter int AM_W  = 7,
   parameter int FB_W  = 3,
   parameter int MOD_W = 22,
   parameter int QUIET = 832
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [2:0]            alg,
   input  logic [FB_W-1:0]       fb,
   input  logic                  full_tick,
   input  logic [3:0]            am_en,
   input  logic [1:0]            am_sens,
   input  logic [AM_W-1:0]       lfo_am,
   input  logic [4*PH_W-1:0]     phase_all,
   input  logic [4*ATT_W-1:0]    att_all,
   output logic                  op_req,
   output logic [1:0]            op_sel,
   output logic [PH_W-1:0]       op_phase,
   output logic [ATT_W:0]        op_att,
   output logic [MOD_W-1:0]      op_mod,
   input  logic                  op_ack,
   input  logic [OUT_W-1:0]      op_out,
   output logic [OUT_W-1:0]      sample,
   output logic                  done
);
   localparam int NOPS  = 4;
   localparam int ACC_W = OUT_W + 2;
   localparam int MEM_W = OUT_W + 1;
   localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (OUT_W-1)) - 1);
   localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

   if (MOD_W < OUT_W + (1 << FB_W)) begin : g_bad_mod
      $error("fm_alg_router: MOD_W too narrow for the feedback shift range");
   end

   seq_state_t              state;
   logic                    launch, step;
   logic [1:0]              idx;
   logic [NOPS-1:0]         quiet;
   logic [ATT_W:0]          eff [NOPS];
   logic [2:0]              alg_q;
   logic [FB_W-1:0]         fb_q;
   logic                    full_q;
   logic signed [OUT_W-1:0] val, c1, r2, r3, r4, smp_q;
   logic signed [MEM_W-1:0] mem_q;
   logic signed [MOD_W-1:0] fb_mod;
   logic signed [ACC_W-1:0] a_c1, a_r2, a_r3, a_r4, a_mem, mod_acc, sum, sat_v;

   for (genvar k = 0; k < NOPS; k++) begin : g_slot
      fm_att_adj #(.ATT_W(ATT_W), .AM_W(AM_W), .QUIET(QUIET)) u_adj (
         .att     (att_all[k*ATT_W +: ATT_W]),
         .am_on   (am_en[k]),
         .lfo_am  (lfo_am),
         .am_sens (am_sens),
         .eff_att (eff[k]),
         .quiet   (quiet[k])
      );
   end

   fm_route_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .quiet  (quiet),
      .op_ack (op_ack),
      .full_q (full_q),
      .alg_hi (alg_q[2]),
      .state  (state),
      .launch (launch),
      .step   (step),
      .op_req (op_req),
      .idx    (idx),
      .done   (done)
   );

   always_comb val = quiet[idx] ? '0 : $signed(op_out);

   fm_fb_hist #(.OUT_W(OUT_W), .MOD_W(MOD_W), .FB_W(FB_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (step && (state == ST_OP1)),
      .new_val  (val),
      .fb       (fb_q),
      .fb_mod   (fb_mod),
      .older    (c1)
   );

   always_comb begin
      a_c1  = ACC_W'(c1);
      a_r2  = ACC_W'(r2);
      a_r3  = ACC_W'(r3);
      a_r4  = ACC_W'(r4);
      a_mem = ACC_W'(mem_q);

      mod_acc = '0;
      case (state)
         ST_OP2: if (alg_q inside {3'd0, 3'd3, 3'd4, 3'd5, 3'd6}) mod_acc = a_c1;
         ST_OP3: if (alg_q inside {3'd0, 3'd1, 3'd2, 3'd5}) mod_acc = a_mem;
         ST_OP4: begin
            case (alg_q)
               3'd0, 3'd1, 3'd4: mod_acc = a_r3;
               3'd2:             mod_acc = a_c1 + a_r3;
               3'd3:             mod_acc = a_mem + a_r3;
               3'd5:             mod_acc = a_c1;
               default:          mod_acc = '0;
            endcase
         end
         default: mod_acc = '0;
      endcase

      case (alg_q)
         3'd4:       sum = a_r2 + a_r4;
         3'd5, 3'd6: sum = a_r2 + a_r3 + a_r4;
         3'd7:       sum = a_c1 + a_r2 + a_r3 + a_r4;
         default:    sum = a_r4;
      endcase
      if (sum > SAT_HI)      sat_v = SAT_HI;
      else if (sum < SAT_LO) sat_v = SAT_LO;
      else                   sat_v = sum;

      op_sel   = idx;
      op_phase = phase_all[idx*PH_W +: PH_W];
      op_att   = eff[idx];
      op_mod   = (state == ST_OP1) ? fb_mod : MOD_W'(mod_acc);
      sample   = smp_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alg_q  <= '0;
         fb_q   <= '0;
         full_q <= 1'b0;
         r2     <= '0;
         r3     <= '0;
         r4     <= '0;
         mem_q  <= '0;
         smp_q  <= '0;
      end else begin
         if (launch) begin
            alg_q  <= alg;
            fb_q   <= fb;
            full_q <= full_tick;
         end
         if (step) begin
            case (state)
               ST_OP2:  r2 <= val;
               ST_OP3:  r3 <= val;
               ST_OP4:  r4 <= val;
               default: ;
            endcase
         end
         if (state == ST_FIN) begin
            if (full_q) smp_q <= OUT_W'(sat_v);
            case (alg_q)
               3'd0, 3'd2, 3'd3: mem_q <= MEM_W'(r2);
               3'd1:             mem_q <= MEM_W'(a_c1 + a_r2);
               3'd5:             if (full_q) mem_q <= MEM_W'(c1);
               default:          ;
            endcase
         end
      end
   end

   // R3
   quiet_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_req |-> (op_att < (ATT_W+1)'(QUIET)));
   // R2
   mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_req && !op_ack |=> op_req && $stable(op_mod) && $stable(op_att));
   // R12
   sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done && $stable(sample));
   // R12
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && start |=> !done && !$stable(op_req) || !done);
endmodule

// File: tb/sim_fm_alg_router.sv
`timescale 1ns/1ps
module sim_fm_alg_router;
   localparam int OUT_W = 14, PH_W = 10, ATT_W = 10, AM_W = 7, FB_W = 3, MOD_W = 22;

   logic                 clk = 0, rst_n = 0, start = 0;
   logic [2:0]           alg = 0;
   logic [FB_W-1:0]      fb = 0;
   logic                 full_tick = 0;
   logic [3:0]           am_en = 0;
   logic [1:0]           am_sens = 0;
   logic [AM_W-1:0]      lfo_am = 0;
   logic [4*PH_W-1:0]    phase_all = 0;
   logic [4*ATT_W-1:0]   att_all = 0;
   logic                 op_req, op_ack = 0;
   logic [1:0]           op_sel;
   logic [PH_W-1:0]      op_phase;
   logic [ATT_W:0]       op_att;
   logic [MOD_W-1:0]     op_mod;
   logic [OUT_W-1:0]     op_out = 0;
   logic [OUT_W-1:0]     sample;
   logic                 done;

   int checks = 0, fails = 0;
   int log_sel[8], log_mod[8], nlog = 0, wait_cnt = 0;
   int e_sel[8], e_mod[8], en;
   int m_ho = 0, m_hn = 0, m_mem = 0, m_smp = 0;

   always #2.5 clk = ~clk;

   fm_alg_router u0 (.clk(clk), .rst_n(rst_n), .start(start), .alg(alg), .fb(fb),
      .full_tick(full_tick), .am_en(am_en), .am_sens(am_sens), .lfo_am(lfo_am),
      .phase_all(phase_all), .att_all(att_all), .op_req(op_req), .op_sel(op_sel),
      .op_phase(op_phase), .op_att(op_att), .op_mod(op_mod), .op_ack(op_ack),
      .op_out(op_out), .sample(sample), .done(done));

   function automatic int opf(int ph, int eff, int md);
      int x;
      x = (ph * 16 + (md & 16383) - eff) & 16383;
      if (x >= 8192) x -= 16384;
      return x;
   endfunction

   // operator unit model with random latency; records each accepted request
   always @(negedge clk) begin
      if (op_ack) begin
         op_ack = 0;
         wait_cnt = $urandom % 3;
      end else if (op_req) begin
         if (wait_cnt == 0) begin
            op_out = OUT_W'(opf(int'(op_phase), int'(op_att), int'($signed(op_mod))));
            op_ack = 1;
            if (nlog < 8) begin
               log_sel[nlog] = int'(op_sel);
               log_mod[nlog] = int'($signed(op_mod));
            end
            nlog++;
         end else wait_cnt--;
      end
   end

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push(int s, int m);
      e_sel[en] = s; e_mod[en] = m; en++;
   endtask

   task automatic do_tick(int a, int f, int fl, int at[4], int ph[4],
                          int amen, int sens, int lfo, bit poke, string tag);
      int eff[4]; bit q[4]; int fbm, c1, v1, v2, v3, v4, md, s, n;
      // expected behaviour
      for (int k = 0; k < 4; k++) begin
         eff[k] = at[k] + (((amen >> k) & 1) ? (lfo >> (3 - sens)) : 0);
         q[k] = eff[k] >= 832;
      end
      en = 0;
      fbm = (f != 0) ? ((m_ho + m_hn) << f) : 0;
      v1 = 0; v2 = 0; v3 = 0; v4 = 0;
      if (!q[0]) begin v1 = opf(ph[0], eff[0], fbm); push(0, fbm); end
      m_ho = m_hn; m_hn = v1; c1 = m_ho;
      if (fl != 0 || a < 4) begin
         md = (a inside {0, 3, 4, 5, 6}) ? c1 : 0;
         if (!q[1]) begin v2 = opf(ph[1], eff[1], md); push(1, md); end
      end
      if (fl != 0) begin
         md = (a inside {0, 1, 2, 5}) ? m_mem : 0;
         if (!q[2]) begin v3 = opf(ph[2], eff[2], md); push(2, md); end
         case (a)
            0, 1, 4: md = v3;
            2:       md = c1 + v3;
            3:       md = m_mem + v3;
            5:       md = c1;
            default: md = 0;
         endcase
         if (!q[3]) begin v4 = opf(ph[3], eff[3], md); push(3, md); end
         case (a)
            4:       s = v2 + v4;
            5, 6:    s = v2 + v3 + v4;
            7:       s = c1 + v2 + v3 + v4;
            default: s = v4;
         endcase
         if (s > 8191) s = 8191;
         if (s < -8192) s = -8192;
         m_smp = s;
      end
      case (a)
         0, 2, 3: m_mem = v2;
         1:       m_mem = c1 + v2;
         5:       if (fl != 0) m_mem = c1;
         default: ;
      endcase
      // drive
      @(negedge clk);
      alg = 3'(a); fb = FB_W'(f); full_tick = fl[0]; am_en = 4'(amen);
      am_sens = 2'(sens); lfo_am = AM_W'(lfo);
      for (int k = 0; k < 4; k++) begin
         att_all[k*ATT_W +: ATT_W] = ATT_W'(at[k]);
         phase_all[k*PH_W +: PH_W] = PH_W'(ph[k]);
      end
      nlog = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      if (poke) begin
         alg = 3'(a ^ 7); full_tick = ~fl[0];
         start = 1;
         @(negedge clk);
         start = 0;
         alg = 3'(a); full_tick = fl[0];
      end
      n = 0;
      while (!done && n < 300) begin @(negedge clk); n++; end
      chk(done == 1'b1, "R12", "done reached", int'(done), 1);
      chk(nlog == en, tag, "request count", nlog, en);
      for (int i = 0; i < en && i < nlog; i++) begin
         chk(log_sel[i] == e_sel[i], "R2", "op_sel order", log_sel[i], e_sel[i]);
         chk(log_mod[i] == e_mod[i], tag, "op_mod", log_mod[i], e_mod[i]);
      end
      chk(int'($signed(sample)) == m_smp, tag, "sample", int'($signed(sample)), m_smp);
      @(negedge clk); @(negedge clk);
      chk(done && int'($signed(sample)) == m_smp, "R12", "sample hold",
          int'($signed(sample)), m_smp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R12 watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int at[4], ph[4];
      void'($urandom(32'd20231));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 0, "R1", "done in reset", int'(done), 0);
      chk(op_req == 0, "R1", "op_req in reset", int'(op_req), 0);
      chk(sample == 0, "R1", "sample in reset", int'(sample), 0);
      rst_n = 1;
      @(negedge clk);
      chk(done == 0 && op_req == 0, "R1", "idle after reset", int'(done), 0);

      // R7 chain algorithms over consecutive ticks (R6, R9 via op_mod)
      at = '{0, 100, 200, 300}; ph = '{17, 290, 400, 77};
      for (int a = 0; a < 4; a++)
         for (int t = 0; t < 3; t++) do_tick(a, 0, 1, at, ph, 0, 0, 0, 0, "R7");
      // R8 parallel algorithms
      for (int a = 4; a < 8; a++)
         for (int t = 0; t < 3; t++) do_tick(a, 0, 1, at, ph, 0, 0, 0, 0, "R8");
      // R6 operator 1 delayed by one tick into operator 2
      ph = '{300, 10, 10, 10};
      do_tick(4, 0, 1, at, ph, 0, 0, 0, 0, "R6");
      ph = '{5, 10, 10, 10};
      do_tick(4, 0, 1, at, ph, 0, 0, 0, 0, "R6");
      // R5 feedback at maximum shift, then quiet op1 shifts zero
      for (int t = 0; t < 3; t++) do_tick(7, 7, 1, at, ph, 0, 0, 0, 0, "R5");
      at = '{900, 0, 0, 0};
      do_tick(7, 3, 1, at, ph, 0, 0, 0, 0, "R5");
      do_tick(7, 3, 1, at, ph, 0, 0, 0, 0, "R5");
      // R3 quiet op2 clears memory in algorithm 0, seen at op3 next tick
      at = '{0, 832, 0, 0};
      do_tick(0, 0, 1, at, ph, 0, 0, 0, 0, "R3");
      at = '{0, 0, 0, 0};
      do_tick(0, 0, 1, at, ph, 0, 0, 0, 0, "R3");
      at = '{0, 831, 0, 832};
      do_tick(6, 0, 1, at, ph, 0, 0, 0, 0, "R3");
      // R4 AM offset pushes over threshold / stays below
      at = '{800, 800, 0, 0};
      do_tick(7, 0, 1, at, ph, 4'b0011, 3, 127, 0, "R4");
      do_tick(7, 0, 1, at, ph, 4'b0011, 0, 127, 0, "R4");
      do_tick(7, 0, 1, at, ph, 4'b0001, 2, 127, 0, "R4");
      // R10 partial ticks, then a full tick reads the memory they wrote
      at = '{10, 20, 30, 40}; ph = '{33, 44, 55, 66};
      do_tick(1, 2, 0, at, ph, 0, 0, 0, 0, "R10");
      do_tick(1, 2, 0, at, ph, 0, 0, 0, 0, "R10");
      do_tick(1, 2, 1, at, ph, 0, 0, 0, 0, "R9");
      do_tick(5, 0, 0, at, ph, 0, 0, 0, 0, "R10");
      do_tick(5, 0, 1, at, ph, 0, 0, 0, 0, "R9");
      do_tick(5, 0, 1, at, ph, 0, 0, 0, 0, "R9");
      // R11 saturation both ways
      at = '{0, 0, 0, 0}; ph = '{511, 511, 511, 511};
      for (int t = 0; t < 2; t++) do_tick(7, 0, 1, at, ph, 0, 0, 0, 0, "R11");
      ph = '{512, 512, 512, 512};
      for (int t = 0; t < 2; t++) do_tick(7, 0, 1, at, ph, 0, 0, 0, 0, "R11");
      // R12 start while busy is ignored
      ph = '{100, 200, 300, 400};
      do_tick(2, 1, 1, at, ph, 0, 0, 0, 1, "R12");
      do_tick(6, 0, 0, at, ph, 0, 0, 0, 1, "R12");
      // random mix
      for (int t = 0; t < 300; t++) begin
         for (int k = 0; k < 4; k++) begin
            at[k] = $urandom % 1024;
            ph[k] = $urandom % 1024;
         end
         do_tick($urandom % 8, $urandom % 8, ($urandom % 4) != 0, at, ph,
                 $urandom % 16, $urandom % 4, $urandom % 128,
                 ($urandom % 8) == 0, "R7");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule